// File: doc/BRIEF.md
# Multi-Port Fan PWM Generator

This block drives several cooling-fan PWM outputs from one system clock. A small set of shared clock types each turns the system clock into a slow PWM tick through two cascaded dividers: a power-of-two stage and an even stage. Each type then counts a programmable period of ticks. Every output port picks one clock type and compares that type's period count against its own 8-bit rise point and 8-bit fall point. The output is high from the rise point up to the fall point. A fall point of zero means the output stays high until the end of the period.

Software programs the block through a word-addressed write bus with a combinational read-back. A global clock enable stops all counting and forces every output low. A per-port enable sets a port to zero duty. Rise and fall values are held in per-port shadow registers. The shadows are reloaded only when the selected period wraps, so a new duty never shortens or splits a pulse already in progress.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset every output is low and every register reads back as zero.
- R2: A clock type's tick interval is 2^H × D system cycles. H is cfg bits [3:0]. D is 1 when L (cfg bits [7:4]) is zero, and 2·L otherwise.
- R3: The period counter of a clock type advances by one on each tick and wraps to zero after reaching the period field P (cfg bits [15:8]). One period is therefore P+1 ticks.
- R4: An enabled port is high while the count c satisfies rise ≤ c < fall_eff, where fall_eff is the fall point, or 256 when the fall point is 0. When rise > fall_eff the high window wraps: c ≥ rise or c < fall_eff. Equal nonzero rise and fall points give a constant low.
- R5: A rise point of 0 with a fall point of 0 holds the output high for the whole period (100 % duty).
- R6: A port whose enable bit (control bit 8+p) is clear drives its output low.
- R7: When the global clock-enable bit (control bit 0) is clear, all outputs are low and all divider and period counters are held at zero.
- R8: Duty register at word address 4+p/2 holds two ports. The even port uses bits [7:0] for rise and [15:8] for fall. The odd port uses bits [23:16] for rise and [31:24] for fall.
- R9: A port's 2-bit clock-type code has its bit 0 at control bit 16+p and its bit 1 at control bit 24+p. Codes 0, 1 and 2 select types 0, 1 and 2. Code 3 selects type 0.
- R10: A rise or fall value written while a port runs takes effect only from the start of the next period of that port's clock type. While the port is disabled or the global enable is off, the value is taken at once.
- R11: The control word (address 0) and the type configuration words (addresses 1 to 3, bits [15:0]) read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 4 | One PWM output per port |

## Verification
On every cycle, assertions check the following:
- The divider and period counters clear while the global enable is off.
- The period count holds between ticks and returns to zero after a wrap.
- The shadow duty values of a running port change only at a period boundary.
- No output is high while the global enable is off.

Some behaviour only the bench scenarios can show:
- Actual duty counts for normal, wrapped, full and empty windows.
- The divider ratio seen as a pulse length.
- The deferred effect of a mid-period duty write.
- The mapping of the type code, including the reserved code.

The bench shows these by comparing the outputs every cycle against a behavioural model.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int HDIV_W = 4;
  localparam int LDIV_W = 4;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = (1 << HDIV_W) + LDIV_W;
  localparam int DUTY_BASE = 4;

  typedef struct packed {
    logic [CNT_W-1:0]  period;
    logic [LDIV_W-1:0] ldiv;
    logic [HDIV_W-1:0] hdiv;
  } type_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
  } duty_t;
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_TYPES = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  clk_en_o,
  output logic [NUM_PORTS-1:0]  port_en_o,
  output logic [1:0]            tsel_o [NUM_PORTS],
  output type_cfg_t             cfg_o  [NUM_TYPES],
  output duty_t                 duty_o [NUM_PORTS]
);
  localparam int NUM_DREGS = (NUM_PORTS + 1) / 2;
  localparam int CFG_W     = $bits(type_cfg_t);
  localparam int DUTY_W    = $bits(duty_t);

  logic ctrl_sel;
  assign ctrl_sel = wr_en_i && (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_o  <= 1'b0;
      port_en_o <= '0;
      for (int p = 0; p < NUM_PORTS; p++) tsel_o[p] <= '0;
    end else if (ctrl_sel) begin
      clk_en_o <= wdata_i[0];
      for (int p = 0; p < NUM_PORTS; p++) begin
        port_en_o[p] <= wdata_i[8+p];
        tsel_o[p]    <= {wdata_i[24+p], wdata_i[16+p]};
      end
    end
  end

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_o[t] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(1 + t)) cfg_o[t] <= type_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_duty
    localparam int LSB = (p % 2) * DUTY_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) duty_o[p] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(DUTY_BASE + p / 2))
        duty_o[p] <= duty_t'(wdata_i[LSB +: DUTY_W]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[0] = clk_en_o;
      for (int p = 0; p < NUM_PORTS; p++) begin
        rdata_o[8+p]  = port_en_o[p];
        rdata_o[16+p] = tsel_o[p][0];
        rdata_o[24+p] = tsel_o[p][1];
      end
    end
    for (int t = 0; t < NUM_TYPES; t++)
      if (addr_i == ADDR_W'(1 + t)) rdata_o[CFG_W-1:0] = cfg_o[t];
    for (int r = 0; r < NUM_DREGS; r++)
      if (addr_i == ADDR_W'(DUTY_BASE + r)) begin
        rdata_o[DUTY_W-1:0] = duty_o[2*r];
        if (2*r + 1 < NUM_PORTS) rdata_o[2*DUTY_W-1:DUTY_W] = duty_o[2*r+1];
      end
  end
endmodule

// File: rtl/fan_pwm_clk_type.sv
module fan_pwm_clk_type
  import fan_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  type_cfg_t        cfg_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pre_cnt, ldiv_val, total, last;
  logic             tick;

  always_comb begin
    ldiv_val = (cfg_i.ldiv == '0) ? PRE_W'(1) : PRE_W'({cfg_i.ldiv, 1'b0});
    total    = ldiv_val << cfg_i.hdiv;
    last     = total - PRE_W'(1);
  end

  assign tick   = clk_en_i && (pre_cnt >= last);
  assign wrap_o = tick && (cnt_o >= cfg_i.period);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      cnt_o   <= '0;
    end else if (!clk_en_i) begin
      pre_cnt <= '0;
      cnt_o   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      cnt_o   <= wrap_o ? '0 : cnt_o + CNT_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  assert_gate_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> (cnt_o == '0 && pre_cnt == '0));
  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !tick) |=> $stable(cnt_o));
  assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == '0);
endmodule

// File: rtl/fan_pwm_port.sv
module fan_pwm_port
  import fan_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  duty_t            duty_i,
  output logic             pwm_o
);
  duty_t          sh;
  logic [CNT_W:0] fall_eff, rise_x, cnt_x;
  logic           win;

  // shadow reloads only at a period boundary while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sh <= '0;
    else if (!active_i || wrap_i) sh <= duty_i;
  end

  always_comb begin
    fall_eff = (sh.fall == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, sh.fall};
    rise_x   = {1'b0, sh.rise};
    cnt_x    = {1'b0, cnt_i};
    if (rise_x <= fall_eff) win = (cnt_x >= rise_x) && (cnt_x < fall_eff);
    else                    win = (cnt_x >= rise_x) || (cnt_x < fall_eff);
  end

  assign pwm_o = active_i && win;

  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !wrap_i) |=> $stable(sh));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_TYPES = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_PORTS-1:0] pwm_o
);
  logic                 clk_en;
  logic [NUM_PORTS-1:0] port_en;
  logic [1:0]           tsel [NUM_PORTS];
  type_cfg_t            cfg  [NUM_TYPES];
  duty_t                duty [NUM_PORTS];
  logic [CNT_W-1:0]     tcnt [NUM_TYPES];
  logic [NUM_TYPES-1:0] twrap;

  fan_pwm_regs #(
    .NUM_PORTS(NUM_PORTS), .NUM_TYPES(NUM_TYPES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .clk_en_o(clk_en), .port_en_o(port_en), .tsel_o(tsel), .cfg_o(cfg), .duty_o(duty)
  );

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    fan_pwm_clk_type u_type (
      .clk_i, .rst_ni, .clk_en_i(clk_en), .cfg_i(cfg[t]),
      .cnt_o(tcnt[t]), .wrap_o(twrap[t])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [1:0] sel;
    assign sel = (int'(tsel[p]) >= NUM_TYPES) ? 2'd0 : tsel[p];
    fan_pwm_port u_port (
      .clk_i, .rst_ni,
      .active_i(clk_en && port_en[p]),
      .wrap_i(twrap[sel]),
      .cnt_i(tcnt[sel]),
      .duty_i(duty[p]),
      .pwm_o(pwm_o[p])
    );
  end

  assert_gated_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en |-> pwm_o == '0);
  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pwm_o == '0);
endmodule

// File: tb/fan_pwm_gen_bench.sv
module fan_pwm_gen_bench;
  localparam int NP = 4;
  localparam int NT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pwm;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  fan_pwm_gen u_fan_pwm_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural model
  int m_ctrl;
  int m_cfg [NT];
  int m_duty [NP];
  int m_pre [NT];
  int m_cnt [NT];
  int m_srise [NP];
  int m_sfall [NP];

  function automatic int f_div(int t);
    int h = m_cfg[t] & 15;
    int l = (m_cfg[t] >> 4) & 15;
    return (l == 0 ? 1 : 2 * l) * (1 << h);
  endfunction
  function automatic int f_per(int t);
    return (m_cfg[t] >> 8) & 255;
  endfunction
  function automatic int f_type(int p);
    int c = ((m_ctrl >> (16 + p)) & 1) | (((m_ctrl >> (24 + p)) & 1) << 1);
    return (c >= NT) ? 0 : c;
  endfunction
  function automatic bit f_on(int p);
    return (m_ctrl & 1) && ((m_ctrl >> (8 + p)) & 1);
  endfunction
  function automatic bit f_exp(int p);
    int c, r, f;
    if (!f_on(p)) return 0;
    c = m_cnt[f_type(p)];
    r = m_srise[p];
    f = (m_sfall[p] == 0) ? 256 : m_sfall[p];
    if (r <= f) return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int t = 0; t < NT; t++) begin m_cfg[t] = 0; m_pre[t] = 0; m_cnt[t] = 0; end
      for (int p = 0; p < NP; p++) begin m_duty[p] = 0; m_srise[p] = 0; m_sfall[p] = 0; end
    end else begin
      bit wr [NT];
      for (int t = 0; t < NT; t++)
        wr[t] = (m_ctrl & 1) && (m_pre[t] >= f_div(t) - 1) && (m_cnt[t] >= f_per(t));
      for (int p = 0; p < NP; p++)
        if (!f_on(p) || wr[f_type(p)]) begin
          m_srise[p] = m_duty[p] & 255;
          m_sfall[p] = (m_duty[p] >> 8) & 255;
        end
      for (int t = 0; t < NT; t++) begin
        if (!(m_ctrl & 1)) begin m_pre[t] = 0; m_cnt[t] = 0; end
        else if (m_pre[t] >= f_div(t) - 1) begin
          m_pre[t] = 0;
          m_cnt[t] = wr[t] ? 0 : m_cnt[t] + 1;
        end else m_pre[t] = m_pre[t] + 1;
      end
      if (wr_en) begin
        if (addr == 0) m_ctrl = int'(wdata);
        else if (addr >= 1 && addr <= NT) m_cfg[addr-1] = int'(wdata & 32'hFFFF);
        else if (addr >= 4 && addr < 4 + (NP + 1) / 2) begin
          m_duty[2*(addr-4)]   = int'(wdata & 32'hFFFF);
          m_duty[2*(addr-4)+1] = int'(wdata >> 16);
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        n_cmp++;
        if (pwm[p] !== f_exp(p)) begin
          n_bad++;
          $display("FAIL %s: port %0d pwm=%0b expected %0b at %0t", cur_req, p, pwm[p], f_exp(p), $time);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic count_high(input int p, input int n, input int exp, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[p]) hits++;
    end
    n_cmp++;
    if (hits != exp) begin
      n_bad++;
      $display("FAIL %s: port %0d high %0d of %0d cycles, expected %0d", req, p, hits, n, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (pwm !== '0) begin n_bad++; $display("FAIL R1: pwm=%b expected 0 in reset", pwm); end
    rst_n = 1'b1;
    rd_check(4'd0, 32'h0, "R1");
    rd_check(4'd1, 32'h0, "R1");
    rd_check(4'd4, 32'h0, "R1");

    // types: t0 H0 L0 P9 (10 cyc), t1 H1 L2 P3 (8*4=32 cyc), t2 H0 L1 P4 (2*5=10 cyc)
    cur_req = "R2";
    wr(4'd1, 32'h0000_0900);
    wr(4'd2, 32'h0000_0321);
    wr(4'd3, 32'h0000_0410);
    // R8 packing: p0 r0 f3, p1 r2 f7, p2 r0 f1, p3 r3 f1 (wrapped)
    wr(4'd4, 32'h0702_0300);
    wr(4'd5, 32'h0103_0100);
    // R9: p2 code1 (bit18), p3 code2 (bit27); enables and clk_en
    wr(4'd0, 32'h0804_0F01);
    rd_check(4'd0, 32'h0804_0F01, "R11");
    rd_check(4'd2, 32'h0000_0321, "R11");
    rd_check(4'd5, 32'h0103_0100, "R8");
    repeat (40) @(negedge clk);
    count_high(0, 10, 3, "R4");
    count_high(1, 10, 5, "R8");
    count_high(2, 64, 16, "R2");
    count_high(3, 50, 30, "R4");
    count_high(0, 40, 12, "R3");

    // R5 full duty, R4 equal nonzero points give low
    cur_req = "R10";
    wr(4'd4, 32'h0505_0000);
    repeat (25) @(negedge clk);
    cur_req = "R5";
    count_high(0, 20, 20, "R5");
    count_high(1, 20, 0, "R4");

    // R10: mid-period change back to 3-tick pulse
    cur_req = "R10";
    repeat (3) @(negedge clk);
    wr(4'd4, 32'h0702_0300);
    repeat (25) @(negedge clk);
    count_high(0, 10, 3, "R10");

    // R6: disable port1
    cur_req = "R6";
    wr(4'd0, 32'h0804_0D01);
    count_high(1, 30, 0, "R6");
    count_high(0, 10, 3, "R6");

    // R9: code 3 on port2 -> type 0 (rise0 fall1 -> 1 of 10)
    cur_req = "R9";
    wr(4'd0, 32'h0C04_0D01);
    repeat (15) @(negedge clk);
    count_high(2, 20, 2, "R9");

    // R7: global gate off
    cur_req = "R7";
    wr(4'd0, 32'h0C04_0D00);
    count_high(0, 20, 0, "R7");
    count_high(3, 20, 0, "R7");
    wr(4'd0, 32'h0C04_0D01);
    count_high(0, 10, 3, "R7");
    repeat (50) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule